// File: doc/BRIEF.md
# Dual-Slot Card Bus Controller

This block controls two removable conditional-access card slots that share one card bus. A host drives an 8-bit register port to set a 14-bit card address, pick the slot and the space, either attribute memory or control/IO, and start single-byte card reads and writes. A timed access sequencer drives the shared bus: address setup, a read or write strobe of guaranteed minimum length that stretches while the card holds its ready line low, and one recovery cycle.

Each slot also has a self-timed reset sequencer and a transport-stream pass-through enable. A card-presence input per slot is synchronised and debounced. Any change in debounced presence latches an interrupt. A second control register holds the two transport-output enables and two active-low tuner reset lines, which software pulses.

The access sequencer has four states. AC_IDLE goes to AC_SETUP on launch. AC_SETUP goes to AC_STROBE after one cycle. AC_STROBE goes to AC_RECOVER when the strobe counter is spent and the card is ready. AC_RECOVER returns to AC_IDLE after one cycle.

Each reset sequencer has three states. RS_IDLE goes to RS_DRIVE on a request. RS_DRIVE goes to RS_WAIT when the drive counter is spent. RS_WAIT returns to RS_IDLE once the slot's ready input is high.

Top module: `cacard_busctl`

## Requirements
- R1: Register 1 holds card address bits 6:0 in its bits 7:1, and its bit 0 reads 0. Register 2 holds address bits 13:7 in its bits 6:0, and its bit 7 reads 0. `cb_addr` presents the address that was latched when the access was launched.
- R2: Register 4 bit 7 selects the slot: 0 asserts `cb_sel[0]` and 1 asserts `cb_sel[1]`. Register 4 bit 6 selects the space: 1 is control/IO and drives `cb_iospace` high, 0 is attribute memory.
- R3: A write strobe on register 3 while idle starts one card write of that byte. The write uses the address, slot and space in force at launch.
- R4: A read strobe on register 3 while idle starts one card read. The byte captured at the end of the strobe reads back from register 3 once `busy` has fallen.
- R5: `cb_rd` or `cb_wr` stays high for at least STROBE_CYC cycles. The strobe ends only in a cycle where `cb_ready` is high.
- R6: `busy` is high from launch until the recovery cycle ends. Register-3 strobes while busy start no access, and `cb_addr` holds steady.
- R7: Writing 1 to register 4 bit 5 resets slot 0, and writing 1 to bit 4 resets slot 1. The slot's `slot_rst` line is driven for RST_CYC cycles. The bit then stays set until that slot's `slot_ready` is high, and it then clears itself.
- R8: Writing 0 to a reset bit while that slot's reset runs does not cancel the reset.
- R9: Register 4 bit 3 drives `ts_pass[0]` and bit 2 drives `ts_pass[1]`.
- R10: Register 4 bit 1 reports slot 0 presence and bit 0 reports slot 1 presence, where 0 means a card is present. A report changes only after the synchronised input has differed for DEB_CYC cycles. Shorter glitches are ignored.
- R11: Register 0 bit 0 enables the interrupt. Bit 1 is set on any change of debounced presence and is cleared by writing 1 to it. `irq` is the enable ANDed with the pending bit.
- R12: Register 5 bit 4 drives `ts_out_en[0]` and bit 5 drives `ts_out_en[1]`. Bit 3 drives `tuner_rst_n[0]` and bit 2 drives `tuner_rst_n[1]`. The register resets to 0x0C.
- R13: After reset, `busy`, `irq`, `cb_sel`, `cb_rd`, `cb_wr`, `slot_rst` and `ts_pass` are all 0. Register 4 reads 0x03 with no cards inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (starts a card read at register 3) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| busy | output | 1 | Card access in progress |
| irq | output | 1 | Presence-change interrupt |
| cb_addr | output | 14 | Card bus address |
| cb_wdata | output | 8 | Card bus write data |
| cb_rdata | input | 8 | Card bus read data |
| cb_iospace | output | 1 | 1 = control/IO space, 0 = attribute memory |
| cb_sel | output | 2 | Per-slot card select |
| cb_rd | output | 1 | Read strobe |
| cb_wr | output | 1 | Write strobe |
| cb_ready | input | 1 | Card ready; low stretches the strobe |
| slot_present_n | input | 2 | Raw presence, low = card inserted |
| slot_ready | input | 2 | Per-slot ready after reset |
| slot_rst | output | 2 | Per-slot card reset |
| ts_pass | output | 2 | Per-slot transport pass-through enable |
| ts_out_en | output | 2 | Transport output enables |
| tuner_rst_n | output | 2 | Active-low tuner resets |

## Verification
Several rules are checked on every cycle. Strobe length is checked against STROBE_CYC. The strobe may only end while `cb_ready` is high. The address must hold while busy. A reset drive must last its full RST_CYC cycles, and a reset bit may clear only after ready. A debounced report may only take the synchronised value. The pending bit may rise only after a presence change. The bench alone shows the register layouts and the address split. It also shows that strobes issued while busy are dropped, that a zero write cannot cancel a running reset, and that short presence glitches raise no interrupt.

// File: rtl/cab_pkg.sv
package cab_pkg;
    typedef enum logic [1:0] {AC_IDLE, AC_SETUP, AC_STROBE, AC_RECOVER} acc_state_t;
    typedef enum logic [1:0] {RS_IDLE, RS_DRIVE, RS_WAIT} rst_state_t;

    localparam logic [2:0] RA_IRQ   = 3'd0;
    localparam logic [2:0] RA_ALO   = 3'd1;
    localparam logic [2:0] RA_AHI   = 3'd2;
    localparam logic [2:0] RA_DATA  = 3'd3;
    localparam logic [2:0] RA_BCTL  = 3'd4;
    localparam logic [2:0] RA_BCTL2 = 3'd5;
endpackage

// File: rtl/cab_access.sv
module cab_access
    import cab_pkg::*;
#(
    parameter int STROBE_CYC = 4,
    parameter int AW = 14,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          launch_rd,
    input  logic          launch_slot,
    input  logic          launch_io,
    input  logic [AW-1:0] launch_addr,
    input  logic [DW-1:0] launch_wdata,
    output logic          busy,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] cb_addr,
    output logic [DW-1:0] cb_wdata,
    input  logic [DW-1:0] cb_rdata,
    output logic          cb_iospace,
    output logic [1:0]    cb_sel,
    output logic          cb_rd,
    output logic          cb_wr,
    input  logic          cb_ready
);
    localparam int CW = $clog2(STROBE_CYC + 1);

    acc_state_t    state, nxt;
    logic [CW-1:0] cnt;
    logic          rd_q, slot_q, io_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic          strobe_done;

    assign strobe_done = (cnt == '0) && cb_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= AC_IDLE;
            cnt     <= '0;
            rd_q    <= 1'b0;
            slot_q  <= 1'b0;
            io_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state <= nxt;
            if (state == AC_IDLE && launch) begin
                rd_q    <= launch_rd;
                slot_q  <= launch_slot;
                io_q    <= launch_io;
                addr_q  <= launch_addr;
                wdata_q <= launch_wdata;
            end
            if (state == AC_SETUP)
                cnt <= CW'(STROBE_CYC - 1);
            else if (state == AC_STROBE && cnt != '0)
                cnt <= cnt - 1'b1;
            if (state == AC_STROBE && strobe_done && rd_q)
                rdata_q <= cb_rdata;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            AC_IDLE:    if (launch) nxt = AC_SETUP;
            AC_SETUP:   nxt = AC_STROBE;
            AC_STROBE:  if (strobe_done) nxt = AC_RECOVER;
            AC_RECOVER: nxt = AC_IDLE;
            default:    nxt = AC_IDLE;
        endcase
    end

    always_comb begin
        busy       = (state != AC_IDLE);
        cb_sel     = busy ? (slot_q ? 2'b10 : 2'b01) : 2'b00;
        cb_rd      = (state == AC_STROBE) && rd_q;
        cb_wr      = (state == AC_STROBE) && !rd_q;
        cb_addr    = addr_q;
        cb_wdata   = wdata_q;
        cb_iospace = io_q;
        rdata      = rdata_q;
    end

    // Checker: length of the current strobe run, saturating
    logic          strobe;
    logic [CW-1:0] run_q;
    assign strobe = cb_rd | cb_wr;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else if (!strobe) run_q <= '0;
        else if (run_q != CW'(STROBE_CYC)) run_q <= run_q + 1'b1;
    end

    AST_STROBE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> run_q == CW'(STROBE_CYC)); // R5
    AST_STROBE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> $past(cb_ready)); // R5
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cb_addr)); // R6
    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !busy) |=> busy); // R3
endmodule

// File: rtl/cab_slot_reset.sv
module cab_slot_reset
    import cab_pkg::*;
#(
    parameter int RST_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic card_ready,
    output logic active,
    output logic rst_out
);
    localparam int CW = $clog2(RST_CYC + 1);

    rst_state_t    state, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == RS_IDLE)
                cnt <= CW'(RST_CYC - 1);
            else if (state == RS_DRIVE && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RS_IDLE:  if (start) nxt = RS_DRIVE;
            RS_DRIVE: if (cnt == '0) nxt = RS_WAIT;
            RS_WAIT:  if (card_ready) nxt = RS_IDLE;
            default:  nxt = RS_IDLE;
        endcase
    end

    always_comb begin
        active  = (state != RS_IDLE);
        rst_out = (state == RS_DRIVE);
    end

    // Checker: drive length, saturating
    logic [CW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else if (!rst_out) run_q <= '0;
        else if (run_q != CW'(RST_CYC)) run_q <= run_q + 1'b1;
    end

    AST_RST_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> run_q == CW'(RST_CYC)); // R7
    AST_RST_CLEAR_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(card_ready)); // R7
endmodule

// File: rtl/cab_presence.sv
module cab_presence #(
    parameter int DEB_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic db_n,
    output logic chg
);
    localparam int CW = $clog2(DEB_CYC + 1);

    logic          s1_q, s2_q, db_q, chg_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= 1'b1;
            s2_q  <= 1'b1;
            db_q  <= 1'b1;
            chg_q <= 1'b0;
            cnt   <= '0;
        end else begin
            s1_q  <= pin_n;
            s2_q  <= s1_q;
            chg_q <= 1'b0;
            if (s2_q == db_q) begin
                cnt <= '0;
            end else if (cnt == CW'(DEB_CYC - 1)) begin
                db_q  <= s2_q;
                chg_q <= 1'b1;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign db_n = db_q;
    assign chg  = chg_q;

    AST_DB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(db_q) |-> db_q == $past(s2_q)); // R10
endmodule

// File: rtl/cacard_busctl.sv
module cacard_busctl
    import cab_pkg::*;
#(
    parameter int STROBE_CYC = 4,
    parameter int RST_CYC    = 16,
    parameter int DEB_CYC    = 8,
    parameter int AW         = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          busy,
    output logic          irq,
    output logic [AW-1:0] cb_addr,
    output logic [7:0]    cb_wdata,
    input  logic [7:0]    cb_rdata,
    output logic          cb_iospace,
    output logic [1:0]    cb_sel,
    output logic          cb_rd,
    output logic          cb_wr,
    input  logic          cb_ready,
    input  logic [1:0]    slot_present_n,
    input  logic [1:0]    slot_ready,
    output logic [1:0]    slot_rst,
    output logic [1:0]    ts_pass,
    output logic [1:0]    ts_out_en,
    output logic [1:0]    tuner_rst_n
);
    localparam int LOW_W  = 7;
    localparam int HIGH_W = AW - LOW_W;

    logic [LOW_W-1:0]  alo_q;
    logic [HIGH_W-1:0] ahi_q;
    logic              slot_q, io_q, irq_en_q, pend_q;
    logic [1:0]        ts_q, tso_q, tun_q;
    logic [1:0]        rs_active, rs_start, db_n, chg;
    logic [7:0]        acc_rdata;
    logic              launch, wr_bctl, wr_ictl;

    assign launch  = !busy && (reg_addr == RA_DATA) && (reg_wr || reg_rd);
    assign wr_bctl = reg_wr && (reg_addr == RA_BCTL);
    assign wr_ictl = reg_wr && (reg_addr == RA_IRQ);
    assign rs_start[0] = wr_bctl && reg_wdata[5];
    assign rs_start[1] = wr_bctl && reg_wdata[4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alo_q    <= '0;
            ahi_q    <= '0;
            slot_q   <= 1'b0;
            io_q     <= 1'b0;
            ts_q     <= '0;
            tso_q    <= '0;
            tun_q    <= 2'b11;
            irq_en_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    RA_ALO:   alo_q <= reg_wdata[7:1];
                    RA_AHI:   ahi_q <= reg_wdata[HIGH_W-1:0];
                    RA_BCTL: begin
                        slot_q  <= reg_wdata[7];
                        io_q    <= reg_wdata[6];
                        ts_q[0] <= reg_wdata[3];
                        ts_q[1] <= reg_wdata[2];
                    end
                    RA_BCTL2: begin
                        tso_q[0] <= reg_wdata[4];
                        tso_q[1] <= reg_wdata[5];
                        tun_q[0] <= reg_wdata[3];
                        tun_q[1] <= reg_wdata[2];
                    end
                    RA_IRQ:   irq_en_q <= reg_wdata[0];
                    default: ;
                endcase
            end
            if (|chg)
                pend_q <= 1'b1;
            else if (wr_ictl && reg_wdata[1])
                pend_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_IRQ:   reg_rdata = {6'b0, pend_q, irq_en_q};
            RA_ALO:   reg_rdata = {alo_q, 1'b0};
            RA_AHI:   reg_rdata = 8'(ahi_q);
            RA_DATA:  reg_rdata = acc_rdata;
            RA_BCTL:  reg_rdata = {slot_q, io_q, rs_active[0], rs_active[1],
                                   ts_q[0], ts_q[1], db_n[0], db_n[1]};
            RA_BCTL2: reg_rdata = {2'b00, tso_q[1], tso_q[0], tun_q[0], tun_q[1], 2'b00};
            default:  reg_rdata = 8'h00;
        endcase
    end

    assign irq         = irq_en_q && pend_q;
    assign ts_pass     = ts_q;
    assign ts_out_en   = tso_q;
    assign tuner_rst_n = tun_q;

    cab_access #(.STROBE_CYC(STROBE_CYC), .AW(AW), .DW(8)) u_access (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .launch_rd(!reg_wr), .launch_slot(slot_q), .launch_io(io_q),
        .launch_addr({ahi_q, alo_q}), .launch_wdata(reg_wdata),
        .busy(busy), .rdata(acc_rdata),
        .cb_addr(cb_addr), .cb_wdata(cb_wdata), .cb_rdata(cb_rdata),
        .cb_iospace(cb_iospace), .cb_sel(cb_sel), .cb_rd(cb_rd), .cb_wr(cb_wr),
        .cb_ready(cb_ready)
    );

    for (genvar i = 0; i < 2; i++) begin : g_slot
        cab_slot_reset #(.RST_CYC(RST_CYC)) u_rst (
            .clk(clk), .rst_n(rst_n), .start(rs_start[i]),
            .card_ready(slot_ready[i]), .active(rs_active[i]), .rst_out(slot_rst[i])
        );
        cab_presence #(.DEB_CYC(DEB_CYC)) u_pres (
            .clk(clk), .rst_n(rst_n), .pin_n(slot_present_n[i]),
            .db_n(db_n[i]), .chg(chg[i])
        );
    end

    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(|chg)); // R11
    AST_SEL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cb_sel)); // R2
endmodule

// File: tb/cacard_busctl_test.sv
`timescale 1ns/1ps
module cacard_busctl_test;
    localparam int STROBE_CYC = 4;
    localparam int RST_CYC    = 16;
    localparam int DEB_CYC    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        busy, irq, cb_iospace, cb_rd, cb_wr;
    logic [13:0] cb_addr;
    logic [7:0]  cb_wdata, cb_rdata;
    logic [1:0]  cb_sel, slot_rst, ts_pass, ts_out_en, tuner_rst_n;
    logic        cb_ready = 1'b1;
    logic [1:0]  slot_present_n = 2'b11;
    logic [1:0]  slot_ready = 2'b11;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    cacard_busctl #(.STROBE_CYC(STROBE_CYC), .RST_CYC(RST_CYC), .DEB_CYC(DEB_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .irq(irq),
        .cb_addr(cb_addr), .cb_wdata(cb_wdata), .cb_rdata(cb_rdata), .cb_iospace(cb_iospace),
        .cb_sel(cb_sel), .cb_rd(cb_rd), .cb_wr(cb_wr), .cb_ready(cb_ready),
        .slot_present_n(slot_present_n), .slot_ready(slot_ready), .slot_rst(slot_rst),
        .ts_pass(ts_pass), .ts_out_en(ts_out_en), .tuner_rst_n(tuner_rst_n)
    );

    // Card model: read byte derived from address
    assign cb_rdata = cb_addr[7:0] ^ 8'h5A;

    // Bus monitor, sampled away from the active edge
    int          run = 0, last_run = 0, acc_cnt = 0, rrun = 0, rlast = 0;
    logic        was_strobe = 1'b0, was_rst = 1'b0, cap_rd = 1'b0, cap_io = 1'b0;
    logic [13:0] cap_addr = '0;
    logic [7:0]  cap_wdata = '0;
    logic [1:0]  cap_sel = '0;
    always @(negedge clk) begin
        if (cb_rd || cb_wr) begin
            run++;
            cap_rd = cb_rd; cap_addr = cb_addr; cap_wdata = cb_wdata;
            cap_sel = cb_sel; cap_io = cb_iospace;
        end else if (was_strobe) begin
            last_run = run; run = 0; acc_cnt++;
        end
        was_strobe = cb_rd || cb_wr;
        if (slot_rst[0]) rrun++;
        else if (was_rst) begin rlast = rrun; rrun = 0; end
        was_rst = slot_rst[0];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic card_read();
        @(negedge clk); reg_addr = 3'd3; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Vector: {req[3:0], wr, addr[2:0], data[7:0], exp[7:0]}
    localparam int NV = 10;
    localparam logic [23:0] VEC [0:NV-1] = '{
        {4'd12, 1'b0, 3'd5, 8'h00, 8'h0C},  // R12 reset value
        {4'd13, 1'b0, 3'd4, 8'h00, 8'h03},  // R13 reset value
        {4'd1,  1'b1, 3'd1, 8'hFF, 8'h00},  // R1
        {4'd1,  1'b0, 3'd1, 8'h00, 8'hFE},  // R1 bit 0 reads 0
        {4'd1,  1'b1, 3'd2, 8'hFF, 8'h00},  // R1
        {4'd1,  1'b0, 3'd2, 8'h00, 8'h7F},  // R1 bit 7 reads 0
        {4'd9,  1'b1, 3'd4, 8'hCC, 8'h00},  // R9 and R2 fields
        {4'd9,  1'b0, 3'd4, 8'h00, 8'hCF},  // R9
        {4'd12, 1'b1, 3'd5, 8'h30, 8'h00},  // R12
        {4'd12, 1'b0, 3'd5, 8'h00, 8'h30}   // R12
    };

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state at the pins
        chk(!busy && !irq && cb_sel == 0 && !cb_rd && !cb_wr && slot_rst == 0 && ts_pass == 0,
            "R13 idle pins", {busy, irq, cb_sel, slot_rst, ts_pass}, 0);
        chk(tuner_rst_n == 2'b11, "R12 tuner reset lines", tuner_rst_n, 3);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) wr_reg(VEC[i][18:16], VEC[i][15:8]);
            else begin
                rd_reg(VEC[i][18:16], d);
                chk(d == VEC[i][7:0], $sformatf("R%0d vector %0d", VEC[i][23:20], i), d, VEC[i][7:0]);
            end
        end
        chk(ts_pass == 2'b11, "R9 pass pins", ts_pass, 3);
        chk(ts_out_en == 2'b11 && tuner_rst_n == 2'b00, "R12 output pins",
            {ts_out_en, tuner_rst_n}, 4'hC);

        // R3 write access: address 0x1234, slot 1, control/IO space
        wr_reg(3'd1, 8'h68);
        wr_reg(3'd2, 8'h24);
        wr_reg(3'd4, 8'hC0);
        wr_reg(3'd3, 8'hA5);
        chk(busy, "R6 busy after launch", busy, 1);
        wr_reg(3'd3, 8'h11);          // R6: dropped while busy
        wait_idle();
        repeat (3) @(negedge clk);
        chk(acc_cnt == 1, "R6 one access only", acc_cnt, 1);
        chk(!cap_rd && cap_wdata == 8'hA5, "R3 write data", cap_wdata, 8'hA5);
        chk(cap_addr == 14'h1234, "R1 card address", cap_addr, 14'h1234);
        chk(cap_sel == 2'b10 && cap_io, "R2 slot and space", {cap_sel, cap_io}, 5);
        chk(last_run == STROBE_CYC, "R5 minimum strobe", last_run, STROBE_CYC);

        // R4 read access: address 0x0055, slot 0, attribute memory, stretched
        wr_reg(3'd1, 8'hAA);
        wr_reg(3'd2, 8'h00);
        wr_reg(3'd4, 8'h00);
        cb_ready = 1'b0;
        card_read();
        repeat (10) @(negedge clk);
        cb_ready = 1'b1;
        wait_idle();
        chk(cap_rd && cap_sel == 2'b01 && !cap_io, "R2 read slot 0 attribute",
            {cap_rd, cap_sel, cap_io}, 4'b1010);
        chk(last_run >= 9, "R5 strobe stretched by ready", last_run, 9);
        rd_reg(3'd3, d);
        chk(d == 8'h0F, "R4 read data", d, 8'h0F);

        // R7 slot 0 reset
        slot_ready[0] = 1'b0;
        wr_reg(3'd4, 8'h20);
        chk(slot_rst[0] && !slot_rst[1], "R7 reset driven", slot_rst, 1);
        repeat (RST_CYC + 4) @(negedge clk);
        chk(rlast == RST_CYC, "R7 reset length", rlast, RST_CYC);
        wr_reg(3'd4, 8'h00);           // R8: no cancel
        rd_reg(3'd4, d);
        chk(d[5] == 1'b1, "R8 bit stays set", d, 8'h23);
        slot_ready[0] = 1'b1;
        repeat (3) @(negedge clk);
        rd_reg(3'd4, d);
        chk(d[5] == 1'b0, "R7 bit self-clears", d, 8'h03);

        // R10 glitch ignored, R11 interrupt
        wr_reg(3'd0, 8'h01);
        slot_present_n[0] = 1'b0;
        repeat (3) @(negedge clk);
        slot_present_n[0] = 1'b1;
        repeat (20) @(negedge clk);
        rd_reg(3'd4, d);
        chk(d[1] == 1'b1 && !irq, "R10 glitch ignored", {d[1], irq}, 2);
        slot_present_n[0] = 1'b0;
        repeat (DEB_CYC + 6) @(negedge clk);
        rd_reg(3'd4, d);
        chk(d[1:0] == 2'b01, "R10 slot 0 present", d[1:0], 1);
        chk(irq, "R11 irq on change", irq, 1);
        wr_reg(3'd0, 8'h03);
        rd_reg(3'd0, d);
        chk(!irq && d == 8'h01, "R11 clear pending", {irq, d}, 1);
        wr_reg(3'd0, 8'h00);
        slot_present_n[1] = 1'b0;
        repeat (DEB_CYC + 6) @(negedge clk);
        rd_reg(3'd0, d);
        chk(!irq && d == 8'h02, "R11 masked pending", {irq, d}, 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule